// File: doc/BRIEF.md
# Secure-Gated Interrupt Access Permission Bank

This block keeps one 2-bit permission level for every interrupt of the extended interrupt range. Interrupt ID m (starting at 4096) belongs to word n = (m - 4096) / 16 and field x = (m - 4096) mod 16 of that word. The words form a bank of 32-bit registers that only secure software can program. Each level is a graded grant. Level 0 lets a non-secure agent do nothing with the interrupt. Level 1 lets it set the interrupt pending. Level 2 adds clearing the pending state and reading the active state. Level 3 adds access to the interrupt's routing.

Other distributor logic asks the bank a question through a combinational port. The question gives an interrupt ID, an access class, whether the interrupt is Secure and whether the requester is secure. The answer is allow or deny. Two configuration inputs decide how many words exist: a presence flag for the extended range and a range value. A per-interrupt capability mask marks which interrupts have a programmable level at all.

Top module: `nsperm_bank`

## Requirements
- R1: After reset every field holds level 0. A secure read of any implemented word returns 0, and a non-secure query for a Secure interrupt is denied for every access class.
- R2: Word n sits at byte address 0x3600 + 4n. Bits [2x+1:2x] of word n hold the level of interrupt 4096 + 16n + x. An address outside the bank, or one that is not a multiple of 4, reads 0 and ignores writes.
- R3: A secure write with reg_wr high stores the whole word on the clock edge. reg_rdata shows the addressed word in the cycle after the address is presented.
- R4: When reg_secure is low, a register read returns 0 and a write leaves the bank unchanged.
- R5: A field whose interrupt has its cap_mask bit at 0 reads 0 and ignores writes, and the query port treats it as level 0. cap_mask bit (16n + x) belongs to interrupt 4096 + 16n + x.
- R6: While ext_present is 0, every word reads 0, writes are ignored, and queries see level 0.
- R7: While ext_present is 1, words 0 to (ext_range + 1) * 2 - 1 are implemented, capped at 64. Words above that limit read 0 and ignore writes.
- R8: q_class uses these codes. Codes 0 (set-pending bit) and 1 (set-pending by ID write) need level 1. Codes 2 (clear-pending bit), 3 (clear-pending by ID write) and 4 (active bit read) need level 2. Code 5 (routing access) needs level 3. Codes 6 (active bit write) and 7 (reserved) are never granted. A non-secure query for a Secure interrupt is allowed only when the stored level is at least the level its class needs.
- R9: When q_irq_secure is 0 the query is allowed whatever the stored level.
- R10: When q_req_secure is 1 the query is allowed.
- R11: A query for an ID below 4096, or for an ID whose word is not implemented, sees level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_present | input | 1 | Extended interrupt range is present |
| ext_range | input | 5 | Range value; the number of implemented words is (value + 1) * 2 |
| cap_mask | input | 1024 | Per-interrupt capability mask; bit k belongs to interrupt 4096 + k |
| reg_addr | input | 16 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_secure | input | 1 | The register access is secure |
| reg_rdata | output | 32 | Read data, registered, valid one cycle after the address |
| q_irq_id | input | 13 | Interrupt ID of the query |
| q_class | input | 3 | Access class of the query (codes in R8) |
| q_irq_secure | input | 1 | The queried interrupt is Secure |
| q_req_secure | input | 1 | The querying requester is secure |
| q_allow | output | 1 | Permission result for the query |

## Verification
The hardest case to reach is a word just past the implemented limit. It looks like a normal register, so a write there that is wrongly accepted only shows up if the limit is raised afterwards. The stimulus writes all ones to the first unimplemented word and reads it back. It then widens ext_range so that the word becomes implemented and reads it again, expecting 0. It also drops ext_present, writes, and restores it, and checks that the earlier contents are unchanged. A capability bit is cleared in the middle of a word so that an all-ones write shows one masked field, in both the read data and a routing query.

// File: rtl/nsperm_pkg.sv
// Package: shared class codes and helper functions for the permission bank.
// Assumes levels are 2-bit and each word carries sixteen fields.
package nsperm_pkg;

    typedef enum logic [2:0] {
        ACC_SETPEND = 3'd0,
        ACC_SETBYID = 3'd1,
        ACC_CLRPEND = 3'd2,
        ACC_CLRBYID = 3'd3,
        ACC_ACTRD   = 3'd4,
        ACC_ROUTE   = 3'd5,
        ACC_ACTWR   = 3'd6,
        ACC_RSVD    = 3'd7
    } acc_class_e;

    // Lowest level that grants a class; 4 means never granted.
    function automatic logic [2:0] need_level(input logic [2:0] cls);
        case (cls)
            ACC_SETPEND, ACC_SETBYID:           return 3'd1;
            ACC_CLRPEND, ACC_CLRBYID, ACC_ACTRD: return 3'd2;
            ACC_ROUTE:                          return 3'd3;
            default:                            return 3'd4;
        endcase
    endfunction

    // Widen sixteen capability bits into a 32-bit field mask.
    function automatic logic [31:0] spread_cap(input logic [15:0] cap);
        logic [31:0] m;
        for (int x = 0; x < 16; x++) begin
            m[2*x +: 2] = {2{cap[x]}};
        end
        return m;
    endfunction

    // Number of implemented words for a given configuration.
    function automatic logic [31:0] impl_count(input logic present,
                                               input logic [31:0] range_val,
                                               input logic [31:0] cap);
        logic [31:0] n;
        n = (range_val + 32'd1) << 1;
        if (!present) return 32'd0;
        if (n > cap) return cap;
        return n;
    endfunction

endpackage

// File: rtl/nsperm_decode.sv
// Module: turns a byte address into a word index plus a hit flag.
// Assumes the bank starts at BASE_OFF, words are 4 bytes, and only aligned
// addresses of implemented words hit.
module nsperm_decode
    import nsperm_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BASE_OFF = 'h3600,
    parameter int NUM_REGS = 64,
    parameter int RANGE_W  = 5,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               present,
    input  logic [RANGE_W-1:0] range_cfg,
    output logic [IDX_W-1:0]   idx,
    output logic               hit
);
    logic [ADDR_W-1:0] off;
    logic [31:0]       word_no;
    logic [31:0]       limit;

    // Offset from the bank base and the implemented-word limit.
    always_comb begin
        off     = addr - ADDR_W'(BASE_OFF);
        word_no = 32'(off[ADDR_W-1:2]);
        limit   = impl_count(present, 32'(range_cfg), 32'(NUM_REGS));
        idx     = off[IDX_W+1:2];
        hit     = (addr >= ADDR_W'(BASE_OFF)) && (off[1:0] == 2'b00)
                  && (word_no < limit);
    end
endmodule

// File: rtl/nsperm_regfile.sv
// Module: storage for the permission words with a capability-masked write port.
// Assumes the caller has already qualified wr_en (secure and implemented).
module nsperm_regfile
    import nsperm_pkg::*;
#(
    parameter int NUM_REGS = 64,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int NUM_IRQ = NUM_REGS * 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [31:0]               wdata,
    input  logic [NUM_IRQ-1:0]        cap_mask,
    output logic [NUM_REGS-1:0][31:0] regs
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        // Hold word i; on a matching write keep only the capable fields.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                regs[i] <= wdata & spread_cap(cap_mask[i*16 +: 16]);
            end
        end
    end
endmodule

// File: rtl/nsperm_check.sv
// Module: combinational permission query against the stored levels.
// Assumes IDs start at EXT_BASE_ID; IDs outside the implemented words see level 0.
module nsperm_check
    import nsperm_pkg::*;
#(
    parameter int NUM_REGS    = 64,
    parameter int RANGE_W     = 5,
    parameter int ID_W        = 13,
    parameter int EXT_BASE_ID = 4096,
    localparam int IDX_W      = $clog2(NUM_REGS),
    localparam int NUM_IRQ    = NUM_REGS * 16
) (
    input  logic [NUM_REGS-1:0][31:0] regs,
    input  logic [NUM_IRQ-1:0]        cap_mask,
    input  logic                      present,
    input  logic [RANGE_W-1:0]        range_cfg,
    input  logic [ID_W-1:0]           irq_id,
    input  logic [2:0]                cls,
    input  logic                      irq_secure,
    input  logic                      req_secure,
    output logic                      allow
);
    logic [ID_W-1:0]  rel;
    logic [IDX_W-1:0] widx;
    logic [3:0]       fld;
    logic             in_ext;
    logic [1:0]       level;

    // Locate the field, fetch its level and compare it with the class need.
    always_comb begin
        rel    = irq_id - ID_W'(EXT_BASE_ID);
        widx   = rel[IDX_W+3:4];
        fld    = rel[3:0];
        in_ext = (irq_id >= ID_W'(EXT_BASE_ID))
                 && (32'(rel[ID_W-1:4]) <
                     impl_count(present, 32'(range_cfg), 32'(NUM_REGS)));
        level  = (in_ext && cap_mask[{widx, fld}]) ? regs[widx][{fld, 1'b0} +: 2] : 2'b00;
        allow  = req_secure || !irq_secure || ({1'b0, level} >= need_level(cls));
    end
endmodule

// File: rtl/nsperm_bank.sv
// Module: top of the secure-gated permission bank. It joins the decoder, the
// storage and the query checker, and registers the read data.
// Assumes single-cycle register accesses with whole-word writes.
module nsperm_bank
    import nsperm_pkg::*;
#(
    parameter int NUM_REGS    = 64,
    parameter int ADDR_W      = 16,
    parameter int BASE_OFF    = 'h3600,
    parameter int RANGE_W     = 5,
    parameter int ID_W        = 13,
    parameter int EXT_BASE_ID = 4096,
    localparam int IDX_W      = $clog2(NUM_REGS),
    localparam int NUM_IRQ    = NUM_REGS * 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_present,
    input  logic [RANGE_W-1:0] ext_range,
    input  logic [NUM_IRQ-1:0] cap_mask,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    input  logic               reg_secure,
    output logic [31:0]        reg_rdata,
    input  logic [ID_W-1:0]    q_irq_id,
    input  logic [2:0]         q_class,
    input  logic               q_irq_secure,
    input  logic               q_req_secure,
    output logic               q_allow
);
    logic [IDX_W-1:0]          acc_idx;
    logic                      acc_hit;
    logic                      acc_ok;
    logic [NUM_REGS-1:0][31:0] regs;

    nsperm_decode #(
        .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF),
        .NUM_REGS(NUM_REGS), .RANGE_W(RANGE_W)
    ) u_decode (
        .addr(reg_addr), .present(ext_present), .range_cfg(ext_range),
        .idx(acc_idx), .hit(acc_hit)
    );

    // A register access counts only when secure and on an implemented word.
    always_comb acc_ok = acc_hit && reg_secure;

    nsperm_regfile #(.NUM_REGS(NUM_REGS)) u_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(acc_ok && reg_wr),
        .wr_idx(acc_idx), .wdata(reg_wdata), .cap_mask(cap_mask), .regs(regs)
    );

    // Registered read data, masked by the live capability bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (acc_ok) begin
            reg_rdata <= regs[acc_idx] & spread_cap(cap_mask[{acc_idx, 4'b0000} +: 16]);
        end else begin
            reg_rdata <= '0;
        end
    end

    nsperm_check #(
        .NUM_REGS(NUM_REGS), .RANGE_W(RANGE_W),
        .ID_W(ID_W), .EXT_BASE_ID(EXT_BASE_ID)
    ) u_check (
        .regs(regs), .cap_mask(cap_mask), .present(ext_present),
        .range_cfg(ext_range), .irq_id(q_irq_id), .cls(q_class),
        .irq_secure(q_irq_secure), .req_secure(q_req_secure), .allow(q_allow)
    );
endmodule

// File: rtl/nsperm_bank_chk.sv
// Checker: port-level properties of the permission bank, bound to the top.
module nsperm_bank_chk #(
    parameter int ID_W        = 13,
    parameter int EXT_BASE_ID = 4096
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ext_present,
    input logic            reg_secure,
    input logic [31:0]     reg_rdata,
    input logic [ID_W-1:0] q_irq_id,
    input logic [2:0]      q_class,
    input logic            q_irq_secure,
    input logic            q_req_secure,
    input logic            q_allow
);
    // R4: a non-secure access yields zero read data on the next cycle.
    p_ns_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_secure |=> (reg_rdata == 32'd0));

    // R6: an absent extended range yields zero read data.
    p_absent_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_present |=> (reg_rdata == 32'd0));

    // R9: non-secure interrupts are always allowed.
    p_nsirq_allow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !q_irq_secure |-> q_allow);

    // R10: secure requesters are always allowed.
    p_secreq_allow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q_req_secure |-> q_allow);

    // R8: active-bit write and reserved classes are never granted.
    p_never_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_req_secure && q_irq_secure && (q_class >= 3'd6)) |-> !q_allow);

    // R11: IDs below the extended range see level 0.
    p_low_id_deny_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_req_secure && q_irq_secure && (q_irq_id < ID_W'(EXT_BASE_ID))) |-> !q_allow);
endmodule

bind nsperm_bank nsperm_bank_chk #(.ID_W(ID_W), .EXT_BASE_ID(EXT_BASE_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_present(ext_present), .reg_secure(reg_secure),
    .reg_rdata(reg_rdata), .q_irq_id(q_irq_id), .q_class(q_class),
    .q_irq_secure(q_irq_secure), .q_req_secure(q_req_secure), .q_allow(q_allow)
);

// File: tb/tb_nsperm_bank.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor compares it.
module tb_nsperm_bank;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_present = 1'b1;
    logic [4:0]    ext_range = 5'd1;
    logic [1023:0] cap_mask;
    logic [15:0]   reg_addr = 16'h0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = 32'h0;
    logic          reg_secure = 1'b1;
    logic [31:0]   reg_rdata;
    logic [12:0]   q_irq_id = 13'd4096;
    logic [2:0]    q_class = 3'd0;
    logic          q_irq_secure = 1'b1;
    logic          q_req_secure = 1'b0;
    logic          q_allow;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    int          stamp_q[$];
    string       req_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    nsperm_bank dut (
        .clk(clk), .rst_n(rst_n), .ext_present(ext_present), .ext_range(ext_range),
        .cap_mask(cap_mask), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_secure(reg_secure), .reg_rdata(reg_rdata),
        .q_irq_id(q_irq_id), .q_class(q_class), .q_irq_secure(q_irq_secure),
        .q_req_secure(q_req_secure), .q_allow(q_allow)
    );

    function automatic int need(input int cls);
        if (cls <= 1) return 1;
        if (cls <= 4) return 2;
        if (cls == 5) return 3;
        return 4;
    endfunction

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d, input logic s);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_secure = s; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic s,
                            input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a; reg_secure = s; reg_wr = 1'b0;
        exp_q.push_back(exp); stamp_q.push_back(cyc); req_q.push_back(req);
    endtask

    task automatic query(input int id, input int cls, input logic irqsec,
                         input logic reqsec, input logic exp, input string req);
        @(negedge clk);
        q_irq_id = 13'(id); q_class = 3'(cls);
        q_irq_secure = irqsec; q_req_secure = reqsec;
        #1;
        checks++;
        if (q_allow !== exp) begin
            failures++;
            $display("FAIL %s query id=%0d cls=%0d actual=%0b expected=%0b",
                     req, id, cls, q_allow, exp);
        end
    endtask

    // Monitor: compare read data one cycle after each queued read address.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (stamp_q.size() > 0 && stamp_q[0] < cyc) begin
                logic [31:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                void'(stamp_q.pop_front());
                checks++;
                if (reg_rdata !== e) begin
                    failures++;
                    $display("FAIL %s read actual=%08h expected=%08h", r, reg_rdata, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL all-R watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cap_mask = '1;
        cap_mask[19] = 1'b0;       // interrupt 4096+19: word 1 field 3
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(16'h3600, 1'b1, 32'h0, "R1");
        bus_read(16'h360C, 1'b1, 32'h0, "R1");
        for (int c = 0; c < 8; c++) query(4096, c, 1'b1, 1'b0, 1'b0, "R1");

        // R3: secure write and read back; levels 0,1,2,3 in fields 0..3
        bus_write(16'h3600, 32'hE4E4_E4E4, 1'b1);
        bus_read(16'h3600, 1'b1, 32'hE4E4_E4E4, "R3");
        // R8: graded levels against every class
        for (int x = 0; x < 4; x++)
            for (int c = 0; c < 8; c++)
                query(4096 + x, c, 1'b1, 1'b0, (x >= need(c)), "R8");

        // R5: capability bit cleared for word 1 field 3
        bus_write(16'h3604, 32'hFFFF_FFFF, 1'b1);
        bus_read(16'h3604, 1'b1, 32'hFFFF_FF3F, "R5");
        query(4096 + 19, 5, 1'b1, 1'b0, 1'b0, "R5");
        query(4096 + 18, 5, 1'b1, 1'b0, 1'b1, "R2");

        // R4: non-secure write ignored, non-secure read zero
        bus_write(16'h3600, 32'h0, 1'b0);
        bus_read(16'h3600, 1'b0, 32'h0, "R4");
        bus_read(16'h3600, 1'b1, 32'hE4E4_E4E4, "R4");

        // R2: field position in word 2 and misaligned/outside addresses
        bus_write(16'h3608, 32'h0000_0C00, 1'b1);
        query(4096 + 32 + 5, 5, 1'b1, 1'b0, 1'b1, "R2");
        query(4096 + 32 + 4, 0, 1'b1, 1'b0, 1'b0, "R2");
        bus_write(16'h3602, 32'hFFFF_FFFF, 1'b1);
        bus_read(16'h3600, 1'b1, 32'hE4E4_E4E4, "R2");
        bus_read(16'h3602, 1'b1, 32'h0, "R2");
        bus_read(16'h3000, 1'b1, 32'h0, "R2");

        // R7: last implemented word and the first one beyond
        bus_write(16'h360C, 32'h5555_5555, 1'b1);
        bus_read(16'h360C, 1'b1, 32'h5555_5555, "R7");
        bus_write(16'h3610, 32'hFFFF_FFFF, 1'b1);
        bus_read(16'h3610, 1'b1, 32'h0, "R7");
        query(4096 + 64, 0, 1'b1, 1'b0, 1'b0, "R11");
        @(negedge clk) ext_range = 5'd2;
        bus_read(16'h3610, 1'b1, 32'h0, "R7");
        query(4096 + 64, 0, 1'b1, 1'b0, 1'b0, "R7");
        @(negedge clk) ext_range = 5'd1;

        // R6: extended range absent
        @(negedge clk) ext_present = 1'b0;
        bus_read(16'h3600, 1'b1, 32'h0, "R6");
        query(4096 + 1, 0, 1'b1, 1'b0, 1'b0, "R6");
        bus_write(16'h3600, 32'h0, 1'b1);
        @(negedge clk) ext_present = 1'b1;
        bus_read(16'h3600, 1'b1, 32'hE4E4_E4E4, "R6");

        // R9, R10, R11
        query(4096, 5, 1'b0, 1'b0, 1'b1, "R9");
        query(4096, 6, 1'b1, 1'b1, 1'b1, "R10");
        query(100, 0, 1'b1, 1'b0, 1'b0, "R11");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule